// File: doc/BRIEF.md
# Banked UART Register File

This block is the host-facing register store of a UART. A simple synchronous bus (register address, write data, write and read strobes) reaches a small set of 8-bit registers. The serial engine, FIFOs and baud generator sit outside and only consume the stored values, which appear here as plain outputs. Two one-cycle strobes request clearing of the receive and transmit FIFOs.

The line-control register selects the bank. Its top bit set opens the divisor pair. One key value (0xBF) opens a third bank with the feature register and four flow-control characters. The enhanced-enable bit of the feature register write-protects the transmit trigger field of the FIFO control register and several modem-control bits. Reads are combinational from the stored state. Writes take effect at the clock edge.

Top module: `uart_regbank`

## Requirements
- R1: After reset, every stored register output, both clear strobes and the read data are 0x00.
- R2: Address 3 reaches the line-control register for read and write in every bank.
- R3: With line-control bit 7 clear, address 2 writes the FIFO control register and reads 0x00, and address 4 reads and writes the modem-control register. Addresses 0, 1, 5, 6 and 7 read 0x00, and writes to them change nothing.
- R4: With line-control bit 7 set and the value not 0xBF, address 0 reaches the divisor low byte and address 1 the divisor high byte. Every other address except 3 reads 0x00 and ignores writes.
- R5: With line-control equal to 0xBF, address 2 reaches the feature register, and addresses 4, 5, 6 and 7 reach the first on-character, second on-character, first off-character and second off-character. Addresses 0 and 1 read 0x00 and ignore writes.
- R6: A FIFO-control write always updates bits 7:6 (receive trigger) and bit 0 (enable). It updates bits 5:4 (transmit trigger) only while feature-register bit 4 is 1.
- R7: FIFO-control output bits 3:1 always read 0. Reserved bit 3 and the clear bits are never stored.
- R8: A FIFO-control write with bit 1 set raises the receive-clear strobe, and one with bit 2 set raises the transmit-clear strobe. The strobe is high for exactly the cycle after the write edge.
- R9: Modem-control bits 7:5 and bit 2 change on a write only while feature-register bit 4 is 1. Bits 4:3 and 1:0 always take the written value.
- R10: A read in the same cycle as a write returns the value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Read data, 0 when rd_i is low |
| lcr_o | output | 8 | Line-control value |
| fcr_o | output | 8 | Stored FIFO-control value |
| mcr_o | output | 8 | Modem-control value |
| dll_o | output | 8 | Divisor low byte |
| dlh_o | output | 8 | Divisor high byte |
| efr_o | output | 8 | Feature register |
| xon1_o | output | 8 | First on-character |
| xon2_o | output | 8 | Second on-character |
| xoff1_o | output | 8 | First off-character |
| xoff2_o | output | 8 | Second off-character |
| rx_fifo_clr_o | output | 1 | Receive FIFO clear strobe |
| tx_fifo_clr_o | output | 1 | Transmit FIFO clear strobe |

## Verification
A read and a write can fall in the same cycle. The case that matters is a write to the line-control register that switches banks while the same cycle reads it or another banked address. The read must still decode against the old bank and return the old value. The bench issues combined read-and-write cycles with random addresses, and writes that move into and out of the key value 0xBF. It compares the read data, sampled before the edge, against a model that is updated only after the edge.

// File: rtl/uart_regbank_pkg.sv
package uart_regbank_pkg;
  localparam int unsigned REG_W = 8;
  typedef logic [REG_W-1:0] reg_t;

  // Field positions that the downstream logic decodes
  localparam int unsigned EFR_ENH_BIT   = 4;
  localparam int unsigned FCR_RXCLR_BIT = 1;
  localparam int unsigned FCR_TXCLR_BIT = 2;
  localparam reg_t        FCR_OPEN_MASK = 8'hC1;  // always writable
  localparam reg_t        FCR_PROT_MASK = 8'h30;  // needs enhanced enable
  localparam reg_t        MCR_PROT_MASK = 8'hE4;  // needs enhanced enable

  typedef enum logic [1:0] {BANK_NORM, BANK_DIV, BANK_ENH} bank_e;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_LCR, SEL_FCR, SEL_MCR, SEL_DLL, SEL_DLH, SEL_EFR, SEL_FC
  } reg_sel_e;
endpackage

// File: rtl/uart_bank_decode.sv
module uart_bank_decode
  import uart_regbank_pkg::*;
#(
  parameter int unsigned ADDR_W   = 3,
  parameter int unsigned NUM_FC   = 4,
  parameter int unsigned FC_IDX_W = 2,
  parameter reg_t        ENH_KEY  = 8'hBF
) (
  input  logic [ADDR_W-1:0]   addr_i,
  input  reg_t                lcr_i,
  output reg_sel_e            sel_o,
  output logic [FC_IDX_W-1:0] fc_idx_o
);
  localparam int unsigned A_LO   = 0;
  localparam int unsigned A_HI   = 1;
  localparam int unsigned A_FCTL = 2;
  localparam int unsigned A_LINE = 3;
  localparam int unsigned A_MDM  = 4;
  localparam int unsigned FC_BASE = 4;

  bank_e       bank;
  int unsigned a;

  always_comb begin
    if (lcr_i == ENH_KEY)     bank = BANK_ENH;
    else if (lcr_i[REG_W-1])  bank = BANK_DIV;
    else                      bank = BANK_NORM;
  end

  always_comb begin
    a        = int'(addr_i);
    sel_o    = SEL_NONE;
    fc_idx_o = '0;
    if (a == A_LINE) begin
      sel_o = SEL_LCR;
    end else begin
      unique case (bank)
        BANK_NORM: begin
          if (a == A_FCTL)      sel_o = SEL_FCR;
          else if (a == A_MDM)  sel_o = SEL_MCR;
        end
        BANK_DIV: begin
          if (a == A_LO)        sel_o = SEL_DLL;
          else if (a == A_HI)   sel_o = SEL_DLH;
        end
        BANK_ENH: begin
          if (a == A_FCTL) begin
            sel_o = SEL_EFR;
          end else if (a >= FC_BASE && a < FC_BASE + NUM_FC) begin
            sel_o    = SEL_FC;
            fc_idx_o = FC_IDX_W'(a - FC_BASE);
          end
        end
        default: sel_o = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/uart_core_regs.sv
module uart_core_regs
  import uart_regbank_pkg::*;
#(
  parameter int unsigned NUM_FC   = 4,
  parameter int unsigned FC_IDX_W = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_i,
  input  reg_sel_e                      sel_i,
  input  logic [FC_IDX_W-1:0]           fc_idx_i,
  input  reg_t                          wdata_i,
  output reg_t                          lcr_q,
  output reg_t                          fcr_q,
  output reg_t                          mcr_q,
  output reg_t                          dll_q,
  output reg_t                          dlh_q,
  output reg_t                          efr_q,
  output logic [NUM_FC-1:0][REG_W-1:0]  fc_q,
  output logic                          rx_clr_q,
  output logic                          tx_clr_q
);
  logic enh_on;
  logic lcr_ce, fcr_ce, mcr_ce, dll_ce, dlh_ce, efr_ce;
  reg_t fcr_d, mcr_d, fcr_mask, mcr_mask;
  logic rx_clr_d, tx_clr_d;

  assign enh_on = efr_q[EFR_ENH_BIT];

  assign lcr_ce = wr_i && (sel_i == SEL_LCR);
  assign fcr_ce = wr_i && (sel_i == SEL_FCR);
  assign mcr_ce = wr_i && (sel_i == SEL_MCR);
  assign dll_ce = wr_i && (sel_i == SEL_DLL);
  assign dlh_ce = wr_i && (sel_i == SEL_DLH);
  assign efr_ce = wr_i && (sel_i == SEL_EFR);

  // next-state: write masks
  always_comb begin
    fcr_mask = enh_on ? (FCR_OPEN_MASK | FCR_PROT_MASK) : FCR_OPEN_MASK;
    mcr_mask = enh_on ? '1 : ~MCR_PROT_MASK;
    fcr_d    = (wdata_i & fcr_mask) | (fcr_q & ~fcr_mask);
    mcr_d    = (wdata_i & mcr_mask) | (mcr_q & ~mcr_mask);
    rx_clr_d = fcr_ce && wdata_i[FCR_RXCLR_BIT];
    tx_clr_d = fcr_ce && wdata_i[FCR_TXCLR_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcr_q    <= '0;
      fcr_q    <= '0;
      mcr_q    <= '0;
      dll_q    <= '0;
      dlh_q    <= '0;
      efr_q    <= '0;
      rx_clr_q <= 1'b0;
      tx_clr_q <= 1'b0;
    end else begin
      if (lcr_ce) lcr_q <= wdata_i;
      if (fcr_ce) fcr_q <= fcr_d;
      if (mcr_ce) mcr_q <= mcr_d;
      if (dll_ce) dll_q <= wdata_i;
      if (dlh_ce) dlh_q <= wdata_i;
      if (efr_ce) efr_q <= wdata_i;
      rx_clr_q <= rx_clr_d;
      tx_clr_q <= tx_clr_d;
    end
  end

  for (genvar g = 0; g < NUM_FC; g++) begin : g_fc
    logic ce;
    reg_t q;
    assign ce = wr_i && (sel_i == SEL_FC) && (fc_idx_i == FC_IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (ce) q <= wdata_i;
    end
    assign fc_q[g] = q;
  end
endmodule

// File: rtl/uart_read_mux.sv
module uart_read_mux
  import uart_regbank_pkg::*;
#(
  parameter int unsigned NUM_FC   = 4,
  parameter int unsigned FC_IDX_W = 2
) (
  input  logic                          rd_i,
  input  reg_sel_e                      sel_i,
  input  logic [FC_IDX_W-1:0]           fc_idx_i,
  input  reg_t                          lcr_i,
  input  reg_t                          mcr_i,
  input  reg_t                          dll_i,
  input  reg_t                          dlh_i,
  input  reg_t                          efr_i,
  input  logic [NUM_FC-1:0][REG_W-1:0]  fc_i,
  output reg_t                          rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      unique case (sel_i)
        SEL_LCR: rdata_o = lcr_i;
        SEL_MCR: rdata_o = mcr_i;
        SEL_DLL: rdata_o = dll_i;
        SEL_DLH: rdata_o = dlh_i;
        SEL_EFR: rdata_o = efr_i;
        SEL_FC:  rdata_o = fc_i[fc_idx_i];
        default: rdata_o = '0;  // write-only FIFO control and unmapped
      endcase
    end
  end
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
  import uart_regbank_pkg::*;
#(
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned NUM_FC  = 4,
  parameter logic [7:0]  ENH_KEY = 8'hBF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  addr_i,
  input  logic [7:0]  wdata_i,
  input  logic        wr_i,
  input  logic        rd_i,
  output logic [7:0]  rdata_o,
  output logic [7:0]  lcr_o,
  output logic [7:0]  fcr_o,
  output logic [7:0]  mcr_o,
  output logic [7:0]  dll_o,
  output logic [7:0]  dlh_o,
  output logic [7:0]  efr_o,
  output logic [7:0]  xon1_o,
  output logic [7:0]  xon2_o,
  output logic [7:0]  xoff1_o,
  output logic [7:0]  xoff2_o,
  output logic        rx_fifo_clr_o,
  output logic        tx_fifo_clr_o
);
  localparam int unsigned FC_IDX_W = (NUM_FC > 1) ? $clog2(NUM_FC) : 1;

  logic [1:0]                   rst_pipe;
  logic                         rst_sync_n;
  reg_sel_e                     sel;
  logic [FC_IDX_W-1:0]          fc_idx;
  logic [NUM_FC-1:0][REG_W-1:0] fc_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  uart_bank_decode #(
    .ADDR_W(ADDR_W), .NUM_FC(NUM_FC), .FC_IDX_W(FC_IDX_W), .ENH_KEY(ENH_KEY)
  ) u_decode (
    .addr_i(ADDR_W'(addr_i)), .lcr_i(lcr_o), .sel_o(sel), .fc_idx_o(fc_idx)
  );

  uart_core_regs #(.NUM_FC(NUM_FC), .FC_IDX_W(FC_IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_i(wr_i), .sel_i(sel), .fc_idx_i(fc_idx),
    .wdata_i(wdata_i), .lcr_q(lcr_o), .fcr_q(fcr_o), .mcr_q(mcr_o),
    .dll_q(dll_o), .dlh_q(dlh_o), .efr_q(efr_o), .fc_q(fc_q),
    .rx_clr_q(rx_fifo_clr_o), .tx_clr_q(tx_fifo_clr_o)
  );

  uart_read_mux #(.NUM_FC(NUM_FC), .FC_IDX_W(FC_IDX_W)) u_rmux (
    .rd_i(rd_i), .sel_i(sel), .fc_idx_i(fc_idx), .lcr_i(lcr_o), .mcr_i(mcr_o),
    .dll_i(dll_o), .dlh_i(dlh_o), .efr_i(efr_o), .fc_i(fc_q), .rdata_o(rdata_o)
  );

  assign xon1_o  = fc_q[0];
  assign xon2_o  = fc_q[1];
  assign xoff1_o = fc_q[2];
  assign xoff2_o = fc_q[3];
endmodule

// File: rtl/uart_regbank_chk.sv
module uart_regbank_chk #(
  parameter logic [7:0] ENH_KEY = 8'hBF
) (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] addr_i,
  input logic [7:0] wdata_i,
  input logic       wr_i,
  input logic       rd_i,
  input logic [7:0] rdata_o,
  input logic [7:0] lcr_o,
  input logic [7:0] fcr_o,
  input logic [7:0] mcr_o,
  input logic [7:0] dll_o,
  input logic [7:0] dlh_o,
  input logic [7:0] efr_o,
  input logic [7:0] xon1_o,
  input logic [7:0] xon2_o,
  input logic [7:0] xoff1_o,
  input logic [7:0] xoff2_o,
  input logic       rx_fifo_clr_o,
  input logic       tx_fifo_clr_o
);
  // R2
  lcr_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && addr_i == 3'd3) |-> (rdata_o == lcr_o));

  // R3
  fcr_wo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && addr_i == 3'd2 && !lcr_o[7]) |-> (rdata_o == 8'h00));

  // R4
  div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lcr_o[7] |=> $stable({dlh_o, dll_o}));

  // R5
  enh_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lcr_o != ENH_KEY) |=> $stable({efr_o, xon1_o, xon2_o, xoff1_o, xoff2_o}));

  // R6
  tx_trig_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !efr_o[4] |=> $stable(fcr_o[5:4]));

  // R9
  mcr_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !efr_o[4] |=> $stable({mcr_o[7:5], mcr_o[2]}));

  // R8
  rx_clr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_fifo_clr_o |-> $past(wr_i && addr_i == 3'd2 && !lcr_o[7] && wdata_i[1]));

  // R8
  tx_clr_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && addr_i == 3'd2 && !lcr_o[7] && wdata_i[2]) |=> tx_fifo_clr_o);
endmodule

bind uart_regbank uart_regbank_chk #(.ENH_KEY(ENH_KEY)) chk_i (
  .clk(clk), .rst_n(rst_sync_n), .addr_i(addr_i), .wdata_i(wdata_i),
  .wr_i(wr_i), .rd_i(rd_i), .rdata_o(rdata_o), .lcr_o(lcr_o), .fcr_o(fcr_o),
  .mcr_o(mcr_o), .dll_o(dll_o), .dlh_o(dlh_o), .efr_o(efr_o),
  .xon1_o(xon1_o), .xon2_o(xon2_o), .xoff1_o(xoff1_o), .xoff2_o(xoff2_o),
  .rx_fifo_clr_o(rx_fifo_clr_o), .tx_fifo_clr_o(tx_fifo_clr_o)
);

// File: tb/uart_regbank_tb_top.sv
`timescale 1ns/100ps
module uart_regbank_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [7:0] rdata, lcr, fcr, mcr, dll, dlh, efr, xon1, xon2, xoff1, xoff2;
  logic rx_clr, tx_clr;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model
  logic [7:0] m_lcr, m_fcr, m_mcr, m_dll, m_dlh, m_efr;
  logic [7:0] m_fc [4];
  logic e_rx, e_tx;

  always #2.5 clk = ~clk;

  uart_regbank dut_i (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .wdata_i(wdata), .wr_i(wr),
    .rd_i(rd), .rdata_o(rdata), .lcr_o(lcr), .fcr_o(fcr), .mcr_o(mcr),
    .dll_o(dll), .dlh_o(dlh), .efr_o(efr), .xon1_o(xon1), .xon2_o(xon2),
    .xoff1_o(xoff1), .xoff2_o(xoff2), .rx_fifo_clr_o(rx_clr),
    .tx_fifo_clr_o(tx_clr)
  );

  function automatic int bank_of();
    if (m_lcr == 8'hBF) return 2;
    if (m_lcr[7])       return 1;
    return 0;
  endfunction

  function automatic logic [7:0] model_read(input logic [2:0] a);
    if (a == 3'd3) return m_lcr;
    case (bank_of())
      0: if (a == 3'd4) return m_mcr;
      1: begin
        if (a == 3'd0) return m_dll;
        if (a == 3'd1) return m_dlh;
      end
      default: begin
        if (a == 3'd2) return m_efr;
        if (a >= 3'd4) return m_fc[a - 3'd4];
      end
    endcase
    return 8'h00;
  endfunction

  task automatic model_write(input logic [2:0] a, input logic [7:0] d);
    int b = bank_of();
    e_rx = 1'b0; e_tx = 1'b0;
    if (a == 3'd3) m_lcr = d;
    else if (b == 0 && a == 3'd2) begin
      m_fcr[7:6] = d[7:6];
      m_fcr[0]   = d[0];
      if (m_efr[4]) m_fcr[5:4] = d[5:4];
      e_rx = d[1]; e_tx = d[2];
    end else if (b == 0 && a == 3'd4) begin
      if (m_efr[4]) m_mcr = d;
      else begin
        m_mcr[4:3] = d[4:3];
        m_mcr[1:0] = d[1:0];
      end
    end else if (b == 1 && a == 3'd0) m_dll = d;
    else if (b == 1 && a == 3'd1) m_dlh = d;
    else if (b == 2 && a == 3'd2) m_efr = d;
    else if (b == 2 && a >= 3'd4) m_fc[a - 3'd4] = d;
  endtask

  task automatic chk(input string tag, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%02h exp=%02h", tag, what, act, exp);
    end
  endtask

  task automatic check_outs(input string tag);
    chk(tag, "lcr", lcr, m_lcr);
    chk(tag, "fcr", fcr, m_fcr);
    chk(tag, "mcr", mcr, m_mcr);
    chk(tag, "dll", dll, m_dll);
    chk(tag, "dlh", dlh, m_dlh);
    chk(tag, "efr", efr, m_efr);
    chk(tag, "xon1", xon1, m_fc[0]);
    chk(tag, "xon2", xon2, m_fc[1]);
    chk(tag, "xoff1", xoff1, m_fc[2]);
    chk(tag, "xoff2", xoff2, m_fc[3]);
    chk({tag, "/R8"}, "rx_clr", {7'd0, rx_clr}, {7'd0, e_rx});
    chk({tag, "/R8"}, "tx_clr", {7'd0, tx_clr}, {7'd0, e_tx});
  endtask

  // one bus cycle: inputs set at the falling edge, read sampled before
  // the rising edge, registers compared at the next falling edge
  task automatic step(input logic [2:0] a, input logic [7:0] d,
                      input logic w, input logic r, input string tag);
    addr = a; wdata = d; wr = w; rd = r;
    #1;
    chk({tag, "/R10"}, "rdata", rdata, r ? model_read(a) : 8'h00);
    @(posedge clk);
    if (w) model_write(a, d);
    else begin e_rx = 1'b0; e_tx = 1'b0; end
    @(negedge clk);
    wr = 1'b0; rd = 1'b0;
    check_outs(tag);
  endtask

  function automatic string tag_for(input logic [2:0] a);
    if (a == 3'd3) return "R2";
    case (bank_of())
      0: return (a == 3'd2) ? "R6" : ((a == 3'd4) ? "R9" : "R3");
      1: return "R4";
      default: return "R5";
    endcase
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_lcr = 0; m_fcr = 0; m_mcr = 0; m_dll = 0; m_dlh = 0; m_efr = 0;
    foreach (m_fc[i]) m_fc[i] = 0;
    e_rx = 0; e_tx = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check_outs("R1");
    step(3'd3, 8'h00, 1'b0, 1'b1, "R1");

    // R2 line control reachable
    step(3'd3, 8'h5A, 1'b1, 1'b1, "R2");
    step(3'd3, 8'h00, 1'b1, 1'b1, "R2");

    // R3 normal bank
    step(3'd4, 8'hFF, 1'b1, 1'b0, "R9");   // locked bits stay 0
    step(3'd4, 8'h00, 1'b0, 1'b1, "R3");
    step(3'd2, 8'hF1, 1'b1, 1'b1, "R6");   // tx trigger locked
    step(3'd2, 8'h00, 1'b0, 1'b1, "R3");
    step(3'd0, 8'h77, 1'b1, 1'b1, "R3");
    step(3'd7, 8'h77, 1'b1, 1'b1, "R3");

    // R4 divisor bank
    step(3'd3, 8'h80, 1'b1, 1'b0, "R4");
    step(3'd0, 8'h34, 1'b1, 1'b1, "R4");
    step(3'd1, 8'h12, 1'b1, 1'b1, "R4");
    step(3'd0, 8'h00, 1'b0, 1'b1, "R4");
    step(3'd2, 8'h99, 1'b1, 1'b1, "R4");
    step(3'd4, 8'h99, 1'b1, 1'b1, "R4");

    // R5 enhanced bank
    step(3'd3, 8'hBF, 1'b1, 1'b0, "R5");
    step(3'd2, 8'h10, 1'b1, 1'b1, "R5");
    for (int i = 4; i < 8; i++) step(3'(i), 8'(8'hA0 + i), 1'b1, 1'b1, "R5");
    for (int i = 4; i < 8; i++) step(3'(i), 8'h00, 1'b0, 1'b1, "R5");
    step(3'd0, 8'h55, 1'b1, 1'b1, "R5");
    step(3'd1, 8'h55, 1'b1, 1'b1, "R5");

    // R6 / R7 / R9 with enhanced enable set
    step(3'd3, 8'h00, 1'b1, 1'b0, "R6");
    step(3'd2, 8'hF9, 1'b1, 1'b0, "R7");
    step(3'd4, 8'hFF, 1'b1, 1'b1, "R9");

    // R8 clear strobes, then idle cycle with both low
    step(3'd2, 8'h06, 1'b1, 1'b0, "R8");
    step(3'd2, 8'h00, 1'b0, 1'b0, "R8");
    step(3'd2, 8'h02, 1'b1, 1'b0, "R8");
    step(3'd2, 8'h04, 1'b1, 1'b0, "R8");

    // R9 lock after clearing enhanced enable
    step(3'd3, 8'hBF, 1'b1, 1'b0, "R9");
    step(3'd2, 8'h00, 1'b1, 1'b0, "R9");
    step(3'd3, 8'h00, 1'b1, 1'b0, "R9");
    step(3'd4, 8'h00, 1'b1, 1'b1, "R9");
    step(3'd2, 8'h00, 1'b1, 1'b0, "R6");

    // R10 bank switch with same-cycle read
    step(3'd3, 8'hBF, 1'b1, 1'b1, "R10");
    step(3'd2, 8'h5C, 1'b1, 1'b1, "R10");
    step(3'd3, 8'h80, 1'b1, 1'b1, "R10");

    // constrained random mix
    for (int n = 0; n < 3000; n++) begin
      logic [2:0] a;
      logic [7:0] d;
      logic w, r;
      a = 3'($urandom_range(0, 7));
      d = 8'($urandom);
      if (a == 3'd3) begin
        case ($urandom_range(0, 3))
          0: d = 8'hBF;
          1: d = 8'h80;
          2: d = 8'h00;
          default: ;
        endcase
      end
      w = ($urandom_range(0, 99) < 60);
      r = ($urandom_range(0, 99) < 60);
      step(a, d, w, r, tag_for(a));
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule